// File: doc/BRIEF.md
# Flash Command Sequencer with Status

This block is the command front end of a small byte-wide flash array attached to an 8-bit microcontroller bus. It watches bus writes for multi-cycle unlock sequences and uses them to start byte program, sector erase and whole-array erase operations. Each operation runs for a fixed number of clock cycles set by a parameter. While an operation runs, every read returns a status byte instead of array data. The status byte carries a data-polling bit, a toggle bit and an error bit, so software can follow progress. The cell array is modelled as a register memory that is erased to FFh.

A sector erase can be paused with a suspend command. While it is paused, the other sectors can be read normally. A resume command continues the erase from the point where it stopped. A per-sector protection input blocks any program or erase aimed at a protected sector.

Bus accesses use a request channel with `bus_valid`/`bus_ready`. `bus_ready` is held high, so the block never applies back-pressure and a request is taken on every cycle in which `bus_valid` is high. Read data comes back on `rsp_valid`/`rsp_data` exactly one cycle after the read is accepted. The response channel has no ready signal, so the bus master must take the response in that cycle. Writes produce no response.

Top module: `flash_cmd_seq`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted, any operation in progress is abandoned and every array byte becomes FFh. After it is released, the block is in read mode, `rsp_valid` is low, and a read returns the addressed array byte.
- R2: The program unlock is three writes in a row, all with address bits [11:0] as given:
  - AAh to 555h, with at least one `bus_sel` bit high;
  - 55h to AAAh;
  - A0h to 555h.
  The next write gives the data, at the offset `bus_addr[OFS_W-1:0]` in the sector named by the lowest set bit of `bus_sel`, and starts a program operation.
- R3: A program stores (old byte AND data). The operation occupies exactly PGM_CYCLES cycles: the reads accepted on the PGM_CYCLES edges after the data write return status, and the next read returns array data.
- R4: The status byte is {bit7 poll, bit6 toggle, bit5 error, bits 4..0 zero}.
  - Poll is the complement of bit 7 of the byte being written. For an erase it is 0.
  - Toggle is 0 on the first status read of an operation and inverts on each later status read.
  - Error is 0 while the operation runs.
- R5: If a program needs any bit to go from 0 to 1, the array still takes the AND at the end of the window. The block then stays in a failed state until reset. In that state every read returns status with bit5 = 1, the poll bit unchanged and the toggle bit still inverting, and all writes are ignored.
- R6: A write that does not match the next expected step of a sequence returns the block to read mode and changes no array byte. A data write after a broken sequence is not programmed.
- R7: When the `sect_prot` bit of the target sector is 1, a program or sector erase aimed at that sector is dropped. The block stays in read mode, and the next read returns array data.
- R8: After the unlock pair, 80h to 555h followed by a write of 30h with a sector selected erases that sector to FFh. The erase takes SERS_CYCLES cycles. Other sectors keep their data.
- R9: After the unlock pair, 80h to 555h followed by 10h to 555h erases every sector whose `sect_prot` bit is 0 at completion. The erase takes BERS_CYCLES cycles. Protected sectors keep their data.
- R10: A write of B0h to any address during a sector erase suspends it. While suspended:
  - reads of other sectors return array data;
  - reads of the sector being erased return 00h;
  - the remaining erase time does not advance, and the toggle bit keeps its value.
- R11: While suspended, a write of 30h with any `bus_sel` bit high resumes the erase. Status reads continue until the total number of busy edges, counted before and after the suspension, equals SERS_CYCLES.
- R12: A read is accepted whenever `bus_valid` is high and `bus_write` is low. `rsp_valid` is high exactly in the cycle after each accepted read, and is never high otherwise. `bus_ready` is always 1. A read with no `bus_sel` bit high in read mode returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [11:0] are compared for unlock codes |
| bus_sel | input | NUM_SECT | Sector select lines from the address decoder |
| bus_wdata | input | 8 | Write data or command code |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Array byte, status byte, or 00h for a suspended sector |
| sect_prot | input | NUM_SECT | Per-sector protection, 1 = locked |

## Verification
The bench counts busy reads edge by edge. A timer that is off by one cycle shows up as one status read too many or too few, and a timer that keeps running during suspend shortens the resumed window. The bench programs over an existing byte to prove that bits can only clear. It also programs a value that needs a 0-to-1 change: a design that skips the error path returns data instead of a status byte with bit5 set. Broken unlock sequences followed by a would-be data write, and commands aimed at protected sectors, would corrupt stored bytes if they were not dropped. Reset in the middle of an operation and reads of the suspended sector are each checked against the value that a correct design must return.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PGM_ARM,
    S_ERS_ARM,
    S_BUSY_PGM,
    S_BUSY_SERS,
    S_BUSY_BERS,
    S_SUSP,
    S_FAIL
  } fsq_state_e;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PGM    = 8'hA0;
  localparam logic [7:0] CODE_ERS    = 8'h80;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_ALL    = 8'h10;
  localparam logic [7:0] CODE_PAUSE  = 8'hB0;
  localparam logic [7:0] CODE_RESUME = 8'h30;

  localparam logic [11:0] ADR_KEY1 = 12'h555;
  localparam logic [11:0] ADR_KEY2 = 12'hAAA;

endpackage

// File: rtl/fsq_timer.sv
module fsq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign last = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fsq_array.sv
module fsq_array #(
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 8,
  parameter int SECT_W     = 2,
  parameter int OFS_W      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pgm_en,
  input  logic [SECT_W-1:0]   pgm_sect,
  input  logic [OFS_W-1:0]    pgm_ofs,
  input  logic [7:0]          pgm_data,
  input  logic                ers_en,
  input  logic [NUM_SECT-1:0] ers_mask,
  input  logic [SECT_W-1:0]   rd_sect,
  input  logic [OFS_W-1:0]    rd_ofs,
  output logic [7:0]          rd_data,
  output logic [7:0]          pgm_old
);

  logic [NUM_SECT-1:0][7:0] rd_bank;
  logic [NUM_SECT-1:0][7:0] old_bank;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic [7:0] cell_q [SECT_BYTES];

    always_ff @(posedge clk) begin
      if (rst || (ers_en && ers_mask[s])) begin
        for (int b = 0; b < SECT_BYTES; b++) begin
          cell_q[b] <= 8'hFF;
        end
      end else if (pgm_en && pgm_sect == SECT_W'(s)) begin
        cell_q[pgm_ofs] <= cell_q[pgm_ofs] & pgm_data;
      end
    end

    assign rd_bank[s]  = cell_q[rd_ofs];
    assign old_bank[s] = cell_q[pgm_ofs];
  end

  assign rd_data = rd_bank[rd_sect];
  assign pgm_old = old_bank[pgm_sect];

endmodule

// File: rtl/fsq_status.sv
module fsq_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       stat_rd,
  input  logic       poll_bit,
  input  logic       err_bit,
  output logic [7:0] stat_byte
);

  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tgl_q <= 1'b0;
    end else if (stat_rd) begin
      tgl_q <= ~tgl_q;
    end
  end

  assign stat_byte = {poll_bit, tgl_q, err_bit, 5'b0};

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int NUM_SECT    = 4,
  parameter int SECT_BYTES  = 8,
  parameter int ADDR_W      = 12,
  parameter int PGM_CYCLES  = 40,
  parameter int SERS_CYCLES = 200,
  parameter int BERS_CYCLES = 400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_SECT-1:0] bus_sel,
  input  logic [7:0]          bus_wdata,
  output logic                rsp_valid,
  output logic [7:0]          rsp_data,
  input  logic [NUM_SECT-1:0] sect_prot
);

  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int OFS_W   = (SECT_BYTES > 1) ? $clog2(SECT_BYTES) : 1;
  localparam int MAX_A   = (PGM_CYCLES > SERS_CYCLES) ? PGM_CYCLES : SERS_CYCLES;
  localparam int MAX_CYC = (MAX_A > BERS_CYCLES) ? MAX_A : BERS_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // bus decode
  logic              wr_acc, rd_acc;
  logic              at_key1, at_key2;
  logic              sel_any;
  logic [SECT_W-1:0] sel_idx;
  logic [OFS_W-1:0]  ofs;

  assign bus_ready = 1'b1;
  assign wr_acc    = bus_valid && bus_write;
  assign rd_acc    = bus_valid && !bus_write;
  assign at_key1   = (bus_addr[11:0] == ADR_KEY1);
  assign at_key2   = (bus_addr[11:0] == ADR_KEY2);
  assign sel_any   = |bus_sel;
  assign ofs       = bus_addr[OFS_W-1:0];

  always_comb begin
    sel_idx = '0;
    for (int i = NUM_SECT - 1; i >= 0; i--) begin
      if (bus_sel[i]) sel_idx = SECT_W'(i);
    end
  end

  // sequencer state
  fsq_state_e        st_q, st_d;
  logic [SECT_W-1:0] tgt_sect_q;
  logic [OFS_W-1:0]  tgt_ofs_q;
  logic [7:0]        tgt_data_q;
  logic              cap_pgm, cap_sect, cap_all;

  // timer
  logic             t_load, t_run, t_last;
  logic [CNT_W-1:0] t_val, t_cnt;

  // array
  logic                a_pgm_en, a_ers_en;
  logic [NUM_SECT-1:0] a_ers_mask;
  logic [7:0]          a_rd_data, a_pgm_old;

  // status
  logic       is_busy, stat_vis, s_rd;
  logic [7:0] s_byte;
  logic [7:0] rd_value;
  logic       rsp_valid_q;
  logic [7:0] rsp_data_q;

  assign is_busy  = (st_q == S_BUSY_PGM) || (st_q == S_BUSY_SERS) || (st_q == S_BUSY_BERS);
  assign stat_vis = is_busy || (st_q == S_FAIL);
  assign t_run    = is_busy;
  assign s_rd     = rd_acc && stat_vis;

  always_comb begin
    st_d       = st_q;
    cap_pgm    = 1'b0;
    cap_sect   = 1'b0;
    cap_all    = 1'b0;
    t_load     = 1'b0;
    t_val      = '0;
    a_pgm_en   = 1'b0;
    a_ers_en   = 1'b0;
    a_ers_mask = '0;
    unique case (st_q)
      S_IDLE: begin
        if (wr_acc && bus_wdata == CODE_KEY1 && at_key1 && sel_any) st_d = S_UNL1;
      end
      S_UNL1: begin
        if (wr_acc) st_d = (bus_wdata == CODE_KEY2 && at_key2) ? S_UNL2 : S_IDLE;
      end
      S_UNL2: begin
        if (wr_acc) begin
          if (bus_wdata == CODE_PGM && at_key1)      st_d = S_PGM_ARM;
          else if (bus_wdata == CODE_ERS && at_key1) st_d = S_ERS_ARM;
          else                                       st_d = S_IDLE;
        end
      end
      S_PGM_ARM: begin
        if (wr_acc) begin
          if (sel_any && !sect_prot[sel_idx]) begin
            st_d    = S_BUSY_PGM;
            cap_pgm = 1'b1;
            t_load  = 1'b1;
            t_val   = CNT_W'(PGM_CYCLES);
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_ERS_ARM: begin
        if (wr_acc) begin
          if (bus_wdata == CODE_SECT && sel_any && !sect_prot[sel_idx]) begin
            st_d     = S_BUSY_SERS;
            cap_sect = 1'b1;
            t_load   = 1'b1;
            t_val    = CNT_W'(SERS_CYCLES);
          end else if (bus_wdata == CODE_ALL && at_key1) begin
            st_d    = S_BUSY_BERS;
            cap_all = 1'b1;
            t_load  = 1'b1;
            t_val   = CNT_W'(BERS_CYCLES);
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_BUSY_PGM: begin
        if (t_last) begin
          a_pgm_en = 1'b1;
          st_d     = (|(tgt_data_q & ~a_pgm_old)) ? S_FAIL : S_IDLE;
        end
      end
      S_BUSY_SERS: begin
        if (t_last) begin
          a_ers_en   = 1'b1;
          a_ers_mask = NUM_SECT'(1) << tgt_sect_q;
          st_d       = S_IDLE;
        end else if (wr_acc && bus_wdata == CODE_PAUSE) begin
          st_d = S_SUSP;
        end
      end
      S_BUSY_BERS: begin
        if (t_last) begin
          a_ers_en   = 1'b1;
          a_ers_mask = ~sect_prot;
          st_d       = S_IDLE;
        end
      end
      S_SUSP: begin
        if (wr_acc && bus_wdata == CODE_RESUME && sel_any) st_d = S_BUSY_SERS;
      end
      S_FAIL: st_d = S_FAIL;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      tgt_sect_q <= '0;
      tgt_ofs_q  <= '0;
      tgt_data_q <= 8'hFF;
    end else begin
      st_q <= st_d;
      if (cap_pgm) begin
        tgt_sect_q <= sel_idx;
        tgt_ofs_q  <= ofs;
        tgt_data_q <= bus_wdata;
      end else if (cap_sect) begin
        tgt_sect_q <= sel_idx;
        tgt_data_q <= 8'hFF;
      end else if (cap_all) begin
        tgt_data_q <= 8'hFF;
      end
    end
  end

  fsq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .run      (t_run),
    .cnt      (t_cnt),
    .last     (t_last)
  );

  fsq_array #(
    .NUM_SECT   (NUM_SECT),
    .SECT_BYTES (SECT_BYTES),
    .SECT_W     (SECT_W),
    .OFS_W      (OFS_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .pgm_en   (a_pgm_en),
    .pgm_sect (tgt_sect_q),
    .pgm_ofs  (tgt_ofs_q),
    .pgm_data (tgt_data_q),
    .ers_en   (a_ers_en),
    .ers_mask (a_ers_mask),
    .rd_sect  (sel_idx),
    .rd_ofs   (ofs),
    .rd_data  (a_rd_data),
    .pgm_old  (a_pgm_old)
  );

  fsq_status u_status (
    .clk       (clk),
    .rst       (rst),
    .clear     (cap_pgm || cap_sect || cap_all),
    .stat_rd   (s_rd),
    .poll_bit  (~tgt_data_q[7]),
    .err_bit   (st_q == S_FAIL),
    .stat_byte (s_byte)
  );

  always_comb begin
    if (stat_vis)                                    rd_value = s_byte;
    else if (!sel_any)                               rd_value = 8'hFF;
    else if (st_q == S_SUSP && sel_idx == tgt_sect_q) rd_value = 8'h00;
    else                                             rd_value = a_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 8'h00;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_data_q <= rd_value;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import fsq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             rsp_valid,
  input fsq_state_e       st_q,
  input logic [CNT_W-1:0] t_cnt
);

  AST_RST_TO_IDLE: assert property (@(posedge clk) rst |=> (st_q == S_IDLE)); // R1

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rsp_valid); // R12

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !rsp_valid); // R12

  AST_BUSY_TIMER_LIVE: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_BUSY_PGM || st_q == S_BUSY_SERS || st_q == S_BUSY_BERS) |-> (t_cnt != '0)); // R3

  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SUSP) |=> $stable(t_cnt)); // R10

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_FAIL) |=> (st_q == S_FAIL)); // R5

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .rsp_valid (rsp_valid),
  .st_q      (st_q),
  .t_cnt     (t_cnt)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int NS  = 4;
  localparam int PGM = 6;
  localparam int SER = 12;
  localparam int BER = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_ready;
  logic          bus_write = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [NS-1:0] bus_sel = '0;
  logic [7:0]    bus_wdata = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic [NS-1:0] sect_prot = '0;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic tgl = 1'b0;

  logic [7:0] q_exp [$];
  string      q_tag [$];

  always #5 clk = ~clk;

  flash_cmd_seq #(
    .NUM_SECT (NS), .SECT_BYTES (8), .ADDR_W (12),
    .PGM_CYCLES (PGM), .SERS_CYCLES (SER), .BERS_CYCLES (BER)
  ) u0 (
    .clk (clk), .rst (rst), .bus_valid (bus_valid), .bus_ready (bus_ready),
    .bus_write (bus_write), .bus_addr (bus_addr), .bus_sel (bus_sel),
    .bus_wdata (bus_wdata), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .sect_prot (sect_prot)
  );

  // monitor: compares each response against the scoreboard queue
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R12: got response %02h expected none", rsp_data);
      end else begin
        logic [7:0] e;
        string      t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [NS-1:0] s, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [NS-1:0] s, input logic [7:0] exp, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_sel = s;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic stat_reads(input logic poll, input logic err, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      rd(12'h000, 4'b0001, {poll, tgl, err, 5'b0}, tag);
      tgl = ~tgl;
    end
  endtask

  task automatic unlock();
    wr(12'h555, 4'b0001, 8'hAA);
    wr(12'hAAA, 4'b0001, 8'h55);
  endtask

  task automatic program_byte(input int s, input logic [11:0] o, input logic [7:0] d, input logic [7:0] old);
    unlock();
    wr(12'h555, 4'b0001, 8'hA0);
    wr(o, NS'(1) << s, d);
    tgl = 1'b0;
    stat_reads(~d[7], 1'b0, PGM, "R4");
    rd(o, NS'(1) << s, old & d, "R3");
  endtask

  task automatic do_reset();
    bus_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rsp_valid after reset", {7'b0, rsp_valid}, 8'h00);
    check("R12 bus_ready", {7'b0, bus_ready}, 8'h01);
    rd(12'h000, 4'b0001, 8'hFF, "R1");
    rd(12'h007, 4'b1000, 8'hFF, "R1");
    rd(12'h003, 4'b0000, 8'hFF, "R12 no select");

    // R2 R3 R4 program, then AND over an existing byte
    program_byte(0, 12'h002, 8'h5A, 8'hFF);
    program_byte(0, 12'h002, 8'h0A, 8'h5A);

    // R6 broken sequences leave the array untouched
    wr(12'h555, 4'b0001, 8'hAA);
    wr(12'hAAA, 4'b0001, 8'h12);
    wr(12'h002, 4'b0001, 8'h00);
    rd(12'h002, 4'b0001, 8'h0A, "R6 bad second cycle");
    unlock();
    wr(12'h555, 4'b0001, 8'h77);
    wr(12'h002, 4'b0001, 8'h00);
    rd(12'h002, 4'b0001, 8'h0A, "R6 bad command");

    // R7 protection
    program_byte(1, 12'h001, 8'h11, 8'hFF);
    sect_prot = 4'b0010;
    unlock();
    wr(12'h555, 4'b0001, 8'hA0);
    wr(12'h001, 4'b0010, 8'h00);
    rd(12'h001, 4'b0010, 8'h11, "R7 program blocked");
    unlock();
    wr(12'h555, 4'b0001, 8'h80);
    wr(12'h000, 4'b0010, 8'h30);
    rd(12'h001, 4'b0010, 8'h11, "R7 erase blocked");

    // R8 sector erase of sector 0
    program_byte(2, 12'h004, 8'h33, 8'hFF);
    program_byte(3, 12'h005, 8'h44, 8'hFF);
    unlock();
    wr(12'h555, 4'b0001, 8'h80);
    wr(12'h000, 4'b0001, 8'h30);
    tgl = 1'b0;
    stat_reads(1'b0, 1'b0, SER, "R8 busy");
    rd(12'h002, 4'b0001, 8'hFF, "R8 erased");
    rd(12'h004, 4'b0100, 8'h33, "R8 neighbour kept");

    // R10 R11 suspend and resume during erase of sector 2
    unlock();
    wr(12'h555, 4'b0001, 8'h80);
    wr(12'h000, 4'b0100, 8'h30);
    tgl = 1'b0;
    stat_reads(1'b0, 1'b0, 3, "R10 before pause");
    wr(12'h123, 4'b0000, 8'hB0);
    rd(12'h004, 4'b0100, 8'h00, "R10 paused sector");
    rd(12'h005, 4'b1000, 8'h44, "R10 other sector");
    rd(12'h001, 4'b0010, 8'h11, "R10 other sector");
    wr(12'h000, 4'b1000, 8'h30);
    stat_reads(1'b0, 1'b0, SER - 4, "R11 resumed window");
    rd(12'h004, 4'b0100, 8'hFF, "R11 erase done");

    // R9 bulk erase skips protected sector 1
    unlock();
    wr(12'h555, 4'b0001, 8'h80);
    wr(12'h555, 4'b0001, 8'h10);
    tgl = 1'b0;
    stat_reads(1'b0, 1'b0, BER, "R9 busy");
    rd(12'h005, 4'b1000, 8'hFF, "R9 erased");
    rd(12'h001, 4'b0010, 8'h11, "R9 protected kept");

    // R5 failed program: 0A then F0 needs 0->1
    sect_prot = '0;
    program_byte(0, 12'h002, 8'h0A, 8'hFF);
    unlock();
    wr(12'h555, 4'b0001, 8'hA0);
    wr(12'h002, 4'b0001, 8'hF0);
    tgl = 1'b0;
    stat_reads(1'b0, 1'b0, PGM, "R5 busy");
    stat_reads(1'b0, 1'b1, 3, "R5 error status");
    wr(12'h555, 4'b0001, 8'hAA);
    stat_reads(1'b0, 1'b1, 2, "R5 sticky");

    // R1 reset leaves failure, and aborts a running program
    do_reset();
    rd(12'h002, 4'b0001, 8'hFF, "R1 after reset");
    unlock();
    wr(12'h555, 4'b0001, 8'hA0);
    wr(12'h003, 4'b0001, 8'h00);
    tgl = 1'b0;
    stat_reads(1'b1, 1'b0, 2, "R4 before abort");
    do_reset();
    rd(12'h003, 4'b0001, 8'hFF, "R1 abort read mode");
    program_byte(0, 12'h003, 8'h5A, 8'hFF);

    repeat (3) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R12: got %0d missing responses expected 0", q_exp.size());
    end
    done = 1;
    finish_run();
  end

endmodule